// File: doc/BRIEF.md
# Segmented Packet Bus Protocol Checker

This block watches a wide transmit bus that is cut into 128-bit segments. Every segment has its own enable, start-of-packet, end-of-packet, error, channel number and empty-byte count. On each rising clock edge the checker samples all segments together. It checks that the enabled segments are packed from the bottom of the bus and that packets on each channel open and close in pairs. It also works out which byte lanes of each segment hold valid data. Packet mode and burst-interleaved mode are both covered, because the checker keeps one open-packet bit for each channel.

The block is a passive monitor. Each rule has its own violation flag, and each flag stays set until a synchronous reset. A combined error output is the OR of the flags. A registered byte-valid mask gives 16 bits per segment.

Within one cycle, segments are handled in ascending index order. A channel can therefore close on one segment and reopen on a later segment of the same cycle. It can also open and close on a single segment.

Top module: `segbus_checker`

## Requirements
- R1: Whenever any segment enable is high, the enables must have the form 0...01...1, starting at segment 0. Segment 0 not enabled, or a disabled segment below an enabled one, sets `viol_fill` after the clock edge that sampled it.
- R2: A cycle with every segment enable low raises no flag and leaves the per-channel open-packet state unchanged.
- R3: Start, end, error, channel and empty-count inputs on a disabled segment have no effect: they raise no flag, change no channel state, and give that segment a byte-valid mask of 0.
- R4: A start-of-packet on a channel whose packet is already open sets `viol_dup_sop`.
- R5: An enabled segment without start-of-packet on a channel with no open packet sets `viol_orphan`. This includes a lone end-of-packet.
- R6: Start and end together on one enabled segment form a complete packet. It is legal, and it leaves the channel closed.
- R7: Segments in a cycle are handled from index 0 upwards. An end followed by a start for the same channel on a higher segment is legal and leaves the channel open. Packets from different channels may interleave across segments and cycles.
- R8: The byte-valid mask is registered, with one cycle of latency. Segment s uses bits [16s+15:16s], and mask bit j covers data bits [8j+7:8j] of that segment. An enabled segment without end-of-packet gives 16'hFFFF. An end segment with empty count N gives bits j >= N set and bits j < N clear.
- R9: When end-of-packet and error are both high on an enabled segment, the low three bits of the empty count are taken as 000. Bit 3 is kept, so the effective count is 0 or 8.
- R10: Every violation flag stays set until a synchronous reset. Reset clears all flags, the mask, the combined error, and every channel's open-packet state.
- R11: `err_any` is high exactly when at least one violation flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| seg_en | input | NUM_SEG | Per-segment transfer enable |
| seg_sop | input | NUM_SEG | Per-segment start-of-packet |
| seg_eop | input | NUM_SEG | Per-segment end-of-packet |
| seg_err | input | NUM_SEG | Per-segment packet-error marker |
| seg_chan | input | NUM_SEG*CHAN_W | Channel number, segment s at [s*CHAN_W +: CHAN_W] |
| seg_mty | input | NUM_SEG*4 | Empty byte count, segment s at [4s +: 4] |
| byte_valid | output | NUM_SEG*16 | Registered per-segment byte-valid mask |
| viol_fill | output | 1 | Sticky: enable pattern not packed from segment 0 |
| viol_dup_sop | output | 1 | Sticky: second start on an open channel |
| viol_orphan | output | 1 | Sticky: continuation or end on a closed channel |
| err_any | output | 1 | OR of all violation flags |

## Verification
The bench checks the enable patterns that go wrong in different ways: a hole in the middle of the bus, a bus with only the upper segments set, and a completely full bus. A checker that only tested segment 0, or only tested neighbours, would miss one of these cases.

The bench also checks in-cycle ordering. It closes and reopens a channel within one cycle, and it interleaves two channels. A design that updated channel state only once per cycle would flag a false duplicate start or a false orphan here.

Disabled segments carry live start and end bits on an open channel. The bench then follows with a legal end on that channel. If those ignored bits had closed the channel, the legal end would be reported as an orphan.

Further checks cover an error end with a large empty count, which must become 8 empty lanes and not 15. Stickiness is checked through idle cycles. A reset is applied while a channel is open, and a later end on that channel must be flagged as an orphan.

// File: rtl/segbus_pkg.sv
package segbus_pkg;
  localparam int SEG_BYTES = 16;
  localparam int MTY_W     = 4;

  typedef struct packed {
    logic fill;
    logic dup;
    logic orphan;
  } viol_t;

  // Valid-lane mask for one segment; lane j covers bits [8j+7:8j].
  function automatic logic [SEG_BYTES-1:0] lane_mask(
    input logic             en,
    input logic             eop,
    input logic             err,
    input logic [MTY_W-1:0] mty
  );
    logic [MTY_W-1:0] empty_n;
    empty_n = err ? {mty[MTY_W-1], {(MTY_W-1){1'b0}}} : mty;
    if (!en)
      lane_mask = '0;
    else if (!eop)
      lane_mask = '1;
    else
      lane_mask = {SEG_BYTES{1'b1}} << empty_n;
  endfunction
endpackage

// File: rtl/segbus_fill_check.sv
module segbus_fill_check #(
  parameter int NUM_SEG = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SEG-1:0] en,
  output logic               bad
);
  logic [NUM_SEG-1:0] hole;

  // Segment i enabled while segment i-1 is idle marks a hole; index 0 has no lower neighbour.
  assign hole[0] = 1'b0;
  for (genvar i = 1; i < NUM_SEG; i++) begin : g_hole
    assign hole[i] = en[i] & ~en[i-1];
  end

  assign bad = |hole;

  // A packed-from-zero pattern plus one shares no set bit with itself.
  assert_fill_R1: assert property (@(posedge clk) disable iff (rst)
    ((en & (en + 1'b1)) != '0) |-> bad);
  assert_idle_clean_R2: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |-> !bad);
endmodule

// File: rtl/segbus_chan_track.sv
module segbus_chan_track #(
  parameter int NUM_SEG  = 16,
  parameter int NUM_CHAN = 64,
  parameter int CHAN_W   = $clog2(NUM_CHAN)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SEG-1:0]        en,
  input  logic [NUM_SEG-1:0]        sop,
  input  logic [NUM_SEG-1:0]        eop,
  input  logic [NUM_SEG*CHAN_W-1:0] chan,
  output logic                      dup_hit,
  output logic                      orphan_hit
);
  logic [NUM_CHAN-1:0] open_q;
  logic [NUM_CHAN-1:0] open_d;
  logic [CHAN_W-1:0]   cur;

  // Ascending walk: each segment sees the state left by all lower ones.
  always_comb begin
    open_d     = open_q;
    dup_hit    = 1'b0;
    orphan_hit = 1'b0;
    cur        = '0;
    for (int s = 0; s < NUM_SEG; s++) begin
      cur = chan[s*CHAN_W +: CHAN_W];
      if (en[s]) begin
        if (sop[s]) begin
          if (open_d[cur]) dup_hit = 1'b1;
          open_d[cur] = ~eop[s];
        end else if (!open_d[cur]) begin
          orphan_hit = 1'b1;
        end else if (eop[s]) begin
          open_d[cur] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) open_q <= '0;
    else     open_q <= open_d;
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> (open_q == $past(open_q)));
  assert_dup_first_R4: assert property (@(posedge clk) disable iff (rst)
    (en[0] && sop[0] && open_q[chan[CHAN_W-1:0]]) |-> dup_hit);
  assert_orphan_first_R5: assert property (@(posedge clk) disable iff (rst)
    (en[0] && !sop[0] && !open_q[chan[CHAN_W-1:0]]) |-> orphan_hit);
endmodule

// File: rtl/segbus_lane_mask.sv
module segbus_lane_mask #(
  parameter int NUM_SEG = 16
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [NUM_SEG-1:0]                      en,
  input  logic [NUM_SEG-1:0]                      eop,
  input  logic [NUM_SEG-1:0]                      err,
  input  logic [NUM_SEG*segbus_pkg::MTY_W-1:0]    mty,
  output logic [NUM_SEG*segbus_pkg::SEG_BYTES-1:0] mask
);
  import segbus_pkg::*;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [SEG_BYTES-1:0] mask_q;

    always_ff @(posedge clk) begin
      if (rst) mask_q <= '0;
      else     mask_q <= lane_mask(en[s], eop[s], err[s], mty[s*MTY_W +: MTY_W]);
    end

    assign mask[s*SEG_BYTES +: SEG_BYTES] = mask_q;

    assert_off_zero_R3: assert property (@(posedge clk) disable iff (rst)
      !en[s] |=> (mask_q == '0));
    assert_full_body_R8: assert property (@(posedge clk) disable iff (rst)
      (en[s] && !eop[s]) |=> (mask_q == '1));
    assert_err_low_R9: assert property (@(posedge clk) disable iff (rst)
      (en[s] && eop[s] && err[s] && !mty[s*MTY_W + MTY_W-1]) |=> (mask_q == '1));
  end
endmodule

// File: rtl/segbus_checker.sv
module segbus_checker #(
  parameter int NUM_SEG  = 16,
  parameter int NUM_CHAN = 64,
  parameter int CHAN_W   = $clog2(NUM_CHAN)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SEG-1:0]         seg_en,
  input  logic [NUM_SEG-1:0]         seg_sop,
  input  logic [NUM_SEG-1:0]         seg_eop,
  input  logic [NUM_SEG-1:0]         seg_err,
  input  logic [NUM_SEG*CHAN_W-1:0]  seg_chan,
  input  logic [NUM_SEG*4-1:0]       seg_mty,
  output logic [NUM_SEG*16-1:0]      byte_valid,
  output logic                       viol_fill,
  output logic                       viol_dup_sop,
  output logic                       viol_orphan,
  output logic                       err_any
);
  import segbus_pkg::*;

  logic  fill_bad, dup_hit, orphan_hit;
  viol_t viol_q, viol_d;
  logic  err_q;

  segbus_fill_check #(.NUM_SEG(NUM_SEG)) u_fill (
    .clk (clk),
    .rst (rst),
    .en  (seg_en),
    .bad (fill_bad)
  );

  segbus_chan_track #(.NUM_SEG(NUM_SEG), .NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .en         (seg_en),
    .sop        (seg_sop),
    .eop        (seg_eop),
    .chan       (seg_chan),
    .dup_hit    (dup_hit),
    .orphan_hit (orphan_hit)
  );

  segbus_lane_mask #(.NUM_SEG(NUM_SEG)) u_mask (
    .clk  (clk),
    .rst  (rst),
    .en   (seg_en),
    .eop  (seg_eop),
    .err  (seg_err),
    .mty  (seg_mty),
    .mask (byte_valid)
  );

  always_comb begin
    viol_d.fill   = viol_q.fill   | fill_bad;
    viol_d.dup    = viol_q.dup    | dup_hit;
    viol_d.orphan = viol_q.orphan | orphan_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_q <= '0;
      err_q  <= 1'b0;
    end else begin
      viol_q <= viol_d;
      err_q  <= |viol_d;
    end
  end

  assign viol_fill    = viol_q.fill;
  assign viol_dup_sop = viol_q.dup;
  assign viol_orphan  = viol_q.orphan;
  assign err_any      = err_q;

  assert_fill_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    viol_fill |=> viol_fill);
  assert_dup_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    viol_dup_sop |=> viol_dup_sop);
  assert_orphan_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    viol_orphan |=> viol_orphan);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (seg_en == '0 && !viol_fill) |=> !viol_fill);
  assert_err_any_R11: assert property (@(posedge clk) disable iff (rst)
    err_any == (viol_fill | viol_dup_sop | viol_orphan));
endmodule

// File: tb/segbus_checker_tb.sv
module segbus_checker_tb;
  localparam int NS = 8;
  localparam int NC = 16;
  localparam int CW = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NS-1:0]    en = '0, sop = '0, eop = '0, err = '0;
  logic [NS*CW-1:0] chan = '0;
  logic [NS*4-1:0]  mty = '0;
  logic [NS*16-1:0] bv;
  logic             v_fill, v_dup, v_orph, e_any;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  segbus_checker #(.NUM_SEG(NS), .NUM_CHAN(NC), .CHAN_W(CW)) u_dut (
    .clk(clk), .rst(rst), .seg_en(en), .seg_sop(sop), .seg_eop(eop), .seg_err(err),
    .seg_chan(chan), .seg_mty(mty), .byte_valid(bv),
    .viol_fill(v_fill), .viol_dup_sop(v_dup), .viol_orphan(v_orph), .err_any(e_any)
  );

  // {rst_first, en, sop, eop, err, chan, mty, expected {fill,dup,orphan}}
  localparam logic [99:0] VEC [16] = '{
    {1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 32'h0,        32'h0,        3'b000}, // R2 idle
    {1'b0, 8'h01, 8'h01, 8'h01, 8'h00, 32'h1,        32'h5,        3'b000}, // R6 R8 single segment
    {1'b0, 8'h03, 8'h01, 8'h02, 8'h00, 32'h22,       32'h0,        3'b000}, // R7 open then close
    {1'b0, 8'h0F, 8'h03, 8'h08, 8'h08, 32'h4343,     32'hF000,     3'b000}, // R7 R9 interleave, err end
    {1'b0, 8'h03, 8'h02, 8'h01, 8'h00, 32'h33,       32'h3,        3'b000}, // R7 close then reopen
    {1'b0, 8'h00, 8'hFF, 8'hFF, 8'hFF, 32'h33333333, 32'h0,        3'b000}, // R3 disabled junk
    {1'b0, 8'h01, 8'h00, 8'h01, 8'h00, 32'h3,        32'h0,        3'b000}, // R3 ch3 still open
    {1'b0, 8'h05, 8'h05, 8'h05, 8'h00, 32'h605,      32'h0,        3'b100}, // R1 hole
    {1'b1, 8'h02, 8'h02, 8'h02, 8'h00, 32'h10,       32'h0,        3'b100}, // R1 seg0 missing
    {1'b1, 8'h01, 8'h01, 8'h00, 8'h00, 32'h7,        32'h0,        3'b000}, // R4 open
    {1'b0, 8'h01, 8'h01, 8'h00, 8'h00, 32'h7,        32'h0,        3'b010}, // R4 second start
    {1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 32'h0,        32'h0,        3'b010}, // R10 sticky
    {1'b1, 8'h01, 8'h00, 8'h00, 8'h00, 32'h8,        32'h0,        3'b001}, // R5 body, no start
    {1'b1, 8'h01, 8'h00, 8'h01, 8'h00, 32'h9,        32'h0,        3'b001}, // R5 lone end
    {1'b1, 8'hFF, 8'h01, 8'h80, 8'h00, 32'hAAAAAAAA, 32'hF0000000, 3'b000}, // R1 R8 full bus
    {1'b0, 8'hFF, 8'hFF, 8'hFF, 8'h00, 32'h76543210, 32'h0,        3'b000}  // R6 eight packets
  };
  localparam string VREQ [16] = '{"R2", "R6", "R7", "R9", "R7", "R3", "R3", "R1",
                                  "R1", "R4", "R4", "R10", "R5", "R5", "R8", "R6"};

  function automatic logic [NS*16-1:0] model_mask(
    input logic [NS-1:0] e, input logic [NS-1:0] p, input logic [NS-1:0] r, input logic [NS*4-1:0] m);
    logic [NS*16-1:0] res;
    int n;
    res = '0;
    for (int s = 0; s < NS; s++) begin
      n = r[s] ? (m[s*4+3] ? 8 : 0) : int'(m[s*4 +: 4]);
      for (int j = 0; j < 16; j++)
        res[s*16+j] = e[s] && (!p[s] || j >= n);
    end
    return res;
  endfunction

  task automatic check_state(input string req, input logic [2:0] exp_f, input logic [NS*16-1:0] exp_m);
    checks++;
    if ({v_fill, v_dup, v_orph} !== exp_f) begin
      errors++;
      $display("FAIL %s flags: actual=%b expected=%b", req, {v_fill, v_dup, v_orph}, exp_f);
    end
    checks++;
    if (bv !== exp_m) begin
      errors++;
      $display("FAIL %s byte_valid: actual=%h expected=%h", req, bv, exp_m);
    end
    checks++;  // R11
    if (e_any !== (|exp_f)) begin
      errors++;
      $display("FAIL R11 err_any: actual=%b expected=%b", e_any, |exp_f);
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic drive(input logic [NS-1:0] e, input logic [NS-1:0] s, input logic [NS-1:0] p,
                       input logic [NS-1:0] r, input logic [NS*CW-1:0] c, input logic [NS*4-1:0] m);
    en = e; sop = s; eop = p; err = r; chan = c; mty = m;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_state("R10", 3'b000, '0);  // reset state

    for (int i = 0; i < 16; i++) begin
      logic [99:0] v;
      v = VEC[i];
      if (v[99]) begin
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
      end
      drive(v[98:91], v[90:83], v[82:75], v[74:67], v[66:35], v[34:3]);
      check_state(VREQ[i], v[2:0], model_mask(v[98:91], v[82:75], v[74:67], v[34:3]));
    end

    // R10: reset clears flags and mask
    pulse_reset();
    check_state("R10", 3'b000, '0);

    // R10: reset clears an open channel, so a later end is an orphan
    drive(8'h01, 8'h01, 8'h00, 8'h00, 32'hA, 32'h0);
    check_state("R10", 3'b000, 128'hFFFF);
    en = '0; sop = '0;
    pulse_reset();
    drive(8'h01, 8'h00, 8'h01, 8'h00, 32'hA, 32'h0);
    check_state("R10", 3'b001, 128'hFFFF);

    // R10: flags survive several idle cycles
    drive(8'h00, 8'h00, 8'h00, 8'h00, 32'h0, 32'h0);
    drive(8'h00, 8'h00, 8'h00, 8'h00, 32'h0, 32'h0);
    check_state("R10", 3'b001, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule